// File: doc/BRIEF.md
# Privilege Mode Switch Controller

This block sits between a 32-bit processor's simple load/store bus and the rest of a small secure SoC. It splits each address into one of four regions by its two top bits. For the I/O region it picks the target core from the next six bits. It drives one select line per external target, and it answers by itself every access that no external target takes. Every permission rule is applied before the selects are formed, so a blocked access never reaches a core.

The block starts in a privileged loader mode. In that mode the loader can read a 32-byte device secret, use a 2 KiB scratch RAM that only it can see, and read the device ID. It can also write the load address, the load size and a 32-byte derived-identity register. Any write to the switch register moves the block into application mode, and only a reset brings it back. In application mode the secret, the scratch RAM and the device ID are hidden, and the load and identity registers can only be read. Each word of the secret can be read once per reset. Every later read of that word returns zero.

Top module: `pmsc_top`

## Requirements
- R1: Address bits [31:30] pick the region: 2'b00 asserts `sel_rom`, 2'b01 asserts `sel_ram`, 2'b10 is reserved (no select, answered by the block with read data zero), and 2'b11 is I/O. At most one select is high at a time.
- R2: In the I/O region, bits [29:24] pick the core: 6'h00 random source (`sel_trng`), 6'h01 timer, 6'h03 UART, 6'h04 touch, 6'h02 secret store, 6'h10 scratch RAM and 6'h3f system control. The scratch RAM is selected only when in-core bits [23:11] are zero. Any other core number gets no select, and the block answers it with zero.
- R3: A write of any value to the system-control switch word (byte offset 0x20) sets `app_mode`. `app_mode` stays set until `rst_n` is asserted.
- R4: A read of the switch word returns 32'h0 in loader mode and 32'hffffffff in application mode.
- R5: In application mode, secret-store and device-ID reads (system-control offsets 0x10 and 0x14) return zero, and `sel_scratch` is never asserted.
- R6: The load address (0x30), load size (0x34) and identity words (0x40 to 0x5c) reset to zero. Loader-mode writes to them read back, and application-mode writes leave them unchanged.
- R7: The secret is eight 32-bit words at secret-store byte offsets 0x00 to 0x1c. Each word returns its value on its first read after reset and zero on every later read. Writes to the secret store have no effect.
- R8: System-control offset 0x00 reads the first name constant, 0x04 reads the second, and 0x08 reads the version, which is 1.
- R9: An I/O access to any core other than the scratch RAM must be a word access (`bus_size` 2'b10) with address bits [1:0] zero. Any other such access asserts no select, reads zero and changes no state.
- R10: For every access the block answers itself, `bus_ready` is high, with `bus_rdata`, in the cycle after `bus_valid`. `bus_rdata` is zero whenever `bus_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; returns to loader mode |
| bus_valid | input | 1 | Access request, held for one cycle |
| bus_addr | input | 32 | Byte address |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for accesses the block answers |
| bus_ready | output | 1 | Completion of an access the block answers |
| sel_rom | output | 1 | ROM region select |
| sel_ram | output | 1 | RAM region select |
| sel_trng | output | 1 | Random-source core select |
| sel_timer | output | 1 | Timer core select |
| sel_uart | output | 1 | UART core select |
| sel_touch | output | 1 | Touch core select |
| sel_scratch | output | 1 | Privileged scratch RAM select |
| app_mode | output | 1 | 1 once application mode is entered |

## Verification
The assertions assume that `bus_valid` is a single-cycle request. They also assume that an access the block answers is not followed by a second request before its `bus_ready`, so each ready can be traced back to exactly one earlier request. The bench keeps within this: every access task raises `bus_valid` for one cycle and then waits out the response before it issues the next one. The assertions also assume that inputs are stable around the clock edge. The bench drives them only on the falling edge.

// File: rtl/pmsc_pkg.sv
// Package: shared encodings for the privilege mode switch controller.
// Assumes a 32-bit byte-addressed bus with a 2-bit region prefix.
package pmsc_pkg;

    typedef enum logic [1:0] {
        RGN_ROM  = 2'b00,
        RGN_RAM  = 2'b01,
        RGN_RSVD = 2'b10,
        RGN_IO   = 2'b11
    } region_e;

    localparam logic [5:0] CORE_TRNG    = 6'h00;
    localparam logic [5:0] CORE_TIMER   = 6'h01;
    localparam logic [5:0] CORE_SECRET  = 6'h02;
    localparam logic [5:0] CORE_UART    = 6'h03;
    localparam logic [5:0] CORE_TOUCH   = 6'h04;
    localparam logic [5:0] CORE_SCRATCH = 6'h10;
    localparam logic [5:0] CORE_SYSCTL  = 6'h3f;

    localparam logic [1:0] SZ_WORD = 2'b10;

    // System-control word offsets (byte offset / 4)
    localparam logic [7:0] WO_NAME_A  = 8'd0;
    localparam logic [7:0] WO_NAME_B  = 8'd1;
    localparam logic [7:0] WO_VERSION = 8'd2;
    localparam logic [7:0] WO_DEVID_L = 8'd4;
    localparam logic [7:0] WO_DEVID_H = 8'd5;
    localparam logic [7:0] WO_SWITCH  = 8'd8;
    localparam logic [7:0] WO_LD_ADDR = 8'd12;
    localparam logic [7:0] WO_LD_SIZE = 8'd13;
    localparam logic [7:0] WO_IDENT   = 8'd16;

    typedef struct packed {
        logic rom;
        logic ram;
        logic trng;
        logic timer;
        logic uart;
        logic touch;
        logic scratch;
        logic secret;
        logic sysctl;
    } sel_t;

endpackage

// File: rtl/pmsc_addr_decode.sv
// Address decoder with permission gating.
// Produces at most one select per request. Mode and access-width rules are
// applied before the select is formed, so a blocked access selects nothing.
// Assumes app_mode comes from a register (no combinational path back).
module pmsc_addr_decode
    import pmsc_pkg::*;
#(
    parameter int SCRATCH_BYTES = 2048
) (
    input  logic        valid,
    input  logic [1:0]  region,
    input  logic [5:0]  core,
    input  logic [23:0] inner,
    input  logic [1:0]  size,
    input  logic        app_mode,
    output sel_t        sel
);
    localparam int SCR_AW = $clog2(SCRATCH_BYTES);

    logic word_ok;
    logic scr_range;
    logic is_io;

    // Classify the access: full aligned word, scratch window, I/O region.
    always_comb begin
        word_ok   = (size == SZ_WORD) && (inner[1:0] == 2'b00);
        scr_range = (inner[23:SCR_AW] == '0);
        is_io     = (region_e'(region) == RGN_IO);
    end

    // Form the gated selects.
    always_comb begin
        sel         = '0;
        sel.rom     = valid && (region_e'(region) == RGN_ROM);
        sel.ram     = valid && (region_e'(region) == RGN_RAM);
        sel.trng    = valid && is_io && word_ok && (core == CORE_TRNG);
        sel.timer   = valid && is_io && word_ok && (core == CORE_TIMER);
        sel.uart    = valid && is_io && word_ok && (core == CORE_UART);
        sel.touch   = valid && is_io && word_ok && (core == CORE_TOUCH);
        sel.sysctl  = valid && is_io && word_ok && (core == CORE_SYSCTL);
        sel.secret  = valid && is_io && word_ok && !app_mode && (core == CORE_SECRET);
        sel.scratch = valid && is_io && !app_mode && scr_range && (core == CORE_SCRATCH);
    end

endmodule

// File: rtl/pmsc_secret_store.sv
// Read-once secret store.
// Holds WORDS 32-bit secret words from a parameter. Each word gives its
// value on the first read after reset and zero afterwards. It cannot be
// written. Assumes rd_en is already gated by mode and width rules.
module pmsc_secret_store #(
    parameter int             WORDS       = 8,
    parameter logic [255:0]   SECRET_INIT = '0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_en,
    input  logic [21:0] word_off,
    output logic [31:0] rdata
);
    localparam int IDX_W = $clog2(WORDS);

    logic [WORDS-1:0] used_q;
    logic [IDX_W-1:0] idx;
    logic             in_range;
    logic [31:0]      words [WORDS];

    // Unpack the secret parameter into words.
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        assign words[g] = SECRET_INIT[g*32 +: 32];
    end

    // Locate the addressed word and check that it exists.
    always_comb begin
        idx      = word_off[IDX_W-1:0];
        in_range = (word_off[21:IDX_W] == '0) && (int'(idx) < WORDS);
    end

    // Return the word only while it has not been consumed.
    always_comb begin
        rdata = 32'h0;
        if (rd_en && in_range && !used_q[idx]) rdata = words[idx];
    end

    // Mark a word as consumed on its first read.
    always_ff @(posedge clk) begin
        if (!rst_n) used_q <= '0;
        else if (rd_en && in_range) used_q[idx] <= 1'b1;
    end

endmodule

// File: rtl/pmsc_sysctl.sv
// System-control register bank.
// Holds the sticky mode flag, load address, load size and identity words,
// and serves the name, version and device-ID constants. Assumes acc_en is
// only high for full aligned word accesses.
module pmsc_sysctl
    import pmsc_pkg::*;
#(
    parameter int          IDENT_WORDS = 8,
    parameter logic [31:0] NAME_A      = 32'h6d6f6465,
    parameter logic [31:0] NAME_B      = 32'h73776368,
    parameter logic [31:0] VERSION     = 32'd1,
    parameter logic [63:0] DEVICE_ID   = 64'h0123_4567_89ab_cdef
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_en,
    input  logic        we,
    input  logic [21:0] word_off,
    input  logic [31:0] wdata,
    output logic        app_mode,
    output logic [31:0] rdata
);
    localparam int ID_IW = $clog2(IDENT_WORDS);
    localparam int ID_LO = int'(WO_IDENT);
    localparam int ID_HI = ID_LO + IDENT_WORDS;

    logic [7:0]       wo;
    logic             hit;
    logic             wr_priv;
    logic             id_hit;
    logic [ID_IW-1:0] id_idx;
    logic [31:0]      ld_addr_q;
    logic [31:0]      ld_size_q;
    logic [31:0]      ident_q [IDENT_WORDS];

    // Decode the word offset and the write permission.
    always_comb begin
        wo      = word_off[7:0];
        hit     = acc_en && (word_off[21:8] == '0);
        wr_priv = hit && we && !app_mode;
        id_hit  = (int'(wo) >= ID_LO) && (int'(wo) < ID_HI);
        id_idx  = ID_IW'(int'(wo) - ID_LO);
    end

    // Sticky mode flag: any write to the switch word enters application mode.
    always_ff @(posedge clk) begin
        if (!rst_n) app_mode <= 1'b0;
        else if (hit && we && wo == WO_SWITCH) app_mode <= 1'b1;
    end

    // Load address and size, writable only in loader mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_addr_q <= '0;
            ld_size_q <= '0;
        end else if (wr_priv) begin
            if (wo == WO_LD_ADDR) ld_addr_q <= wdata;
            if (wo == WO_LD_SIZE) ld_size_q <= wdata;
        end
    end

    // Identity words, one register per word, writable only in loader mode.
    for (genvar g = 0; g < IDENT_WORDS; g++) begin : g_ident
        always_ff @(posedge clk) begin
            if (!rst_n) ident_q[g] <= '0;
            else if (wr_priv && id_hit && id_idx == ID_IW'(g)) ident_q[g] <= wdata;
        end
    end

    // Read multiplexer; hidden and unknown words read zero.
    always_comb begin
        rdata = 32'h0;
        if (hit && !we) begin
            if (id_hit) begin
                rdata = ident_q[id_idx];
            end else begin
                case (wo)
                    WO_NAME_A:  rdata = NAME_A;
                    WO_NAME_B:  rdata = NAME_B;
                    WO_VERSION: rdata = VERSION;
                    WO_DEVID_L: rdata = app_mode ? 32'h0 : DEVICE_ID[31:0];
                    WO_DEVID_H: rdata = app_mode ? 32'h0 : DEVICE_ID[63:32];
                    WO_SWITCH:  rdata = {32{app_mode}};
                    WO_LD_ADDR: rdata = ld_addr_q;
                    WO_LD_SIZE: rdata = ld_size_q;
                    default:    rdata = 32'h0;
                endcase
            end
        end
    end

endmodule

// File: rtl/pmsc_top.sv
// Privilege mode switch controller, top level.
// Decodes bus requests into region and core selects, serves the secret store
// and the system-control bank, and answers every access no external target
// takes with a registered response one cycle after the request.
// Assumes single-cycle bus_valid pulses.
module pmsc_top
    import pmsc_pkg::*;
#(
    parameter int           SCRATCH_BYTES = 2048,
    parameter int           SECRET_WORDS  = 8,
    parameter int           IDENT_WORDS   = 8,
    parameter logic [255:0] SECRET_INIT   = {8{32'h5a5a_0000}} ^ 256'h7_0000_0006_0000_0005_0000_0004_0000_0003_0000_0002_0000_0001_0000_0000,
    parameter logic [31:0]  NAME_A        = 32'h6d6f6465,
    parameter logic [31:0]  NAME_B        = 32'h73776368,
    parameter logic [63:0]  DEVICE_ID     = 64'h0123_4567_89ab_cdef
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic [31:0] bus_addr,
    input  logic        bus_we,
    input  logic [1:0]  bus_size,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_ready,
    output logic        sel_rom,
    output logic        sel_ram,
    output logic        sel_trng,
    output logic        sel_timer,
    output logic        sel_uart,
    output logic        sel_touch,
    output logic        sel_scratch,
    output logic        app_mode
);
    sel_t        sel;
    logic        external;
    logic        answered;
    logic [31:0] sec_rdata;
    logic [31:0] sys_rdata;
    logic [31:0] rdata_c;

    pmsc_addr_decode #(
        .SCRATCH_BYTES(SCRATCH_BYTES)
    ) u_decode (
        .valid   (bus_valid),
        .region  (bus_addr[31:30]),
        .core    (bus_addr[29:24]),
        .inner   (bus_addr[23:0]),
        .size    (bus_size),
        .app_mode(app_mode),
        .sel     (sel)
    );

    pmsc_secret_store #(
        .WORDS      (SECRET_WORDS),
        .SECRET_INIT(SECRET_INIT)
    ) u_secret (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (sel.secret && !bus_we),
        .word_off(bus_addr[23:2]),
        .rdata   (sec_rdata)
    );

    pmsc_sysctl #(
        .IDENT_WORDS(IDENT_WORDS),
        .NAME_A     (NAME_A),
        .NAME_B     (NAME_B),
        .VERSION    (32'd1),
        .DEVICE_ID  (DEVICE_ID)
    ) u_sysctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_en  (sel.sysctl),
        .we      (bus_we),
        .word_off(bus_addr[23:2]),
        .wdata   (bus_wdata),
        .app_mode(app_mode),
        .rdata   (sys_rdata)
    );

    // Route selects to the ports and find accesses the block must answer.
    always_comb begin
        sel_rom     = sel.rom;
        sel_ram     = sel.ram;
        sel_trng    = sel.trng;
        sel_timer   = sel.timer;
        sel_uart    = sel.uart;
        sel_touch   = sel.touch;
        sel_scratch = sel.scratch;
        external    = sel.rom | sel.ram | sel.trng | sel.timer | sel.uart
                    | sel.touch | sel.scratch;
        answered    = bus_valid && !external;
        rdata_c     = sel.secret ? sec_rdata : (sel.sysctl ? sys_rdata : 32'h0);
    end

    // Register the response for internally answered accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ready <= 1'b0;
            bus_rdata <= 32'h0;
        end else begin
            bus_ready <= answered;
            bus_rdata <= answered ? rdata_c : 32'h0;
        end
    end

endmodule

// File: rtl/pmsc_checker.sv
// Property checker for pmsc_top, attached with bind.
// Assumes single-cycle requests on bus_valid.
module pmsc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic [31:0] bus_addr,
    input logic        bus_we,
    input logic [1:0]  bus_size,
    input logic [31:0] bus_rdata,
    input logic        bus_ready,
    input logic        sel_rom,
    input logic        sel_ram,
    input logic        sel_trng,
    input logic        sel_timer,
    input logic        sel_uart,
    input logic        sel_touch,
    input logic        sel_scratch,
    input logic        app_mode
);
    logic any_ext;
    assign any_ext = sel_rom | sel_ram | sel_trng | sel_timer | sel_uart
                   | sel_touch | sel_scratch;

    a_r1_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_rom, sel_ram, sel_trng, sel_timer, sel_uart, sel_touch, sel_scratch}));

    a_r1_rom_region: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr[31:30] == 2'b00) |-> sel_rom);

    a_r3_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        app_mode |=> app_mode);

    a_r3_mode_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(app_mode) |-> $past(bus_valid && bus_we && bus_size == 2'b10
                                  && bus_addr == 32'hff00_0020));

    a_r5_scratch_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        app_mode |-> !sel_scratch);

    a_r9_narrow_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr[31:30] == 2'b11 && bus_size != 2'b10)
        |-> !(sel_trng || sel_timer || sel_uart || sel_touch));

    a_r10_ready_cause: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> ($past(bus_valid) && !$past(any_ext)));

    a_r10_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |-> bus_rdata == 32'h0);

endmodule

bind pmsc_top pmsc_checker u_pmsc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_size   (bus_size),
    .bus_rdata  (bus_rdata),
    .bus_ready  (bus_ready),
    .sel_rom    (sel_rom),
    .sel_ram    (sel_ram),
    .sel_trng   (sel_trng),
    .sel_timer  (sel_timer),
    .sel_uart   (sel_uart),
    .sel_touch  (sel_touch),
    .sel_scratch(sel_scratch),
    .app_mode   (app_mode)
);

// File: tb/pmsc_top_bench.sv
// Directed bench for pmsc_top: one task per scenario, each self-checking.
module pmsc_top_bench;
    localparam logic [255:0] SEC = 256'h1111_1111_2222_2222_3333_3333_4444_4444_5555_5555_6666_6666_7777_7777_8888_8888;
    localparam logic [31:0]  NA  = 32'h6162_6364;
    localparam logic [31:0]  NB  = 32'h6566_6768;
    localparam logic [63:0]  DID = 64'hfeed_beef_0bad_f00d;
    localparam logic [31:0]  SYS = 32'hff00_0000;
    localparam logic [31:0]  SCR = 32'hc200_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_size = 2'b10;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        sel_rom, sel_ram, sel_trng, sel_timer, sel_uart, sel_touch, sel_scratch;
    logic        app_mode;

    int n_checks = 0;
    int n_fail = 0;
    logic [6:0]  s_sel;
    logic [31:0] s_rd;
    logic        s_rdy;

    always #5 clk = ~clk;

    pmsc_top #(
        .SECRET_INIT(SEC), .NAME_A(NA), .NAME_B(NB), .DEVICE_ID(DID)
    ) u_pmsc_top (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: drive at the falling edge, sample selects mid-cycle,
    // sample the response just after the next rising edge.
    task automatic access(input logic [31:0] a, input logic we, input logic [1:0] sz,
                          input logic [31:0] wd);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_we = we; bus_size = sz; bus_wdata = wd;
        #1;
        s_sel = {sel_rom, sel_ram, sel_trng, sel_timer, sel_uart, sel_touch, sel_scratch};
        @(posedge clk);
        #1;
        s_rdy = bus_ready;
        s_rd  = bus_rdata;
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_word(input logic [31:0] a);
        access(a, 1'b0, 2'b10, 32'h0);
    endtask

    task automatic wr_word(input logic [31:0] a, input logic [31:0] d);
        access(a, 1'b1, 2'b10, d);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        check("R3 reset mode", {31'h0, app_mode}, 32'h0);
        check("R10 reset ready", {31'h0, bus_ready}, 32'h0);
        rd_word(SYS + 32'h30);
        check("R6 load addr reset", s_rd, 32'h0);
        rd_word(SYS + 32'h44);
        check("R6 ident reset", s_rd, 32'h0);
    endtask

    task automatic t_regions();
        rd_word(32'h0000_1000);
        check("R1 rom select", {25'h0, s_sel}, 32'b100_0000);
        check("R10 external not answered", {31'h0, s_rdy}, 32'h0);
        access(32'h4000_0003, 1'b0, 2'b00, 32'h0);
        check("R1 ram select byte", {25'h0, s_sel}, 32'b010_0000);
        rd_word(32'h8000_0000);
        check("R1 reserved no select", {25'h0, s_sel}, 32'h0);
        check("R10 reserved ready", {31'h0, s_rdy}, 32'h1);
        check("R1 reserved zero", s_rd, 32'h0);
    endtask

    task automatic t_cores();
        rd_word(32'hc000_0000); check("R2 trng", {25'h0, s_sel}, 32'b001_0000);
        rd_word(32'hc100_0004); check("R2 timer", {25'h0, s_sel}, 32'b000_1000);
        rd_word(32'hc300_0000); check("R2 uart", {25'h0, s_sel}, 32'b000_0100);
        rd_word(32'hc400_0000); check("R2 touch", {25'h0, s_sel}, 32'b000_0010);
        access(32'hd000_07ff, 1'b0, 2'b00, 32'h0);
        check("R2 scratch byte", {25'h0, s_sel}, 32'b000_0001);
        rd_word(32'hd000_0800);
        check("R2 scratch out of window", {25'h0, s_sel}, 32'h0);
        rd_word(32'hc500_0000);
        check("R2 unknown core no select", {25'h0, s_sel}, 32'h0);
        check("R2 unknown core answered", {31'h0, s_rdy}, 32'h1);
    endtask

    task automatic t_narrow();
        access(32'hc300_0000, 1'b0, 2'b00, 32'h0);
        check("R9 narrow uart", {25'h0, s_sel}, 32'h0);
        rd_word(32'hc000_0002);
        check("R9 misaligned trng", {25'h0, s_sel}, 32'h0);
        access(SYS + 32'h08, 1'b0, 2'b01, 32'h0);
        check("R9 narrow version read zero", s_rd, 32'h0);
        access(SYS + 32'h30, 1'b1, 2'b00, 32'hdead_beef);
        rd_word(SYS + 32'h30);
        check("R9 narrow write ignored", s_rd, 32'h0);
        access(SYS + 32'h20, 1'b1, 2'b01, 32'h1);
        #1;
        check("R9 narrow switch ignored", {31'h0, app_mode}, 32'h0);
    endtask

    task automatic t_names();
        rd_word(SYS + 32'h00); check("R8 name A", s_rd, NA);
        rd_word(SYS + 32'h04); check("R8 name B", s_rd, NB);
        rd_word(SYS + 32'h08); check("R8 version", s_rd, 32'h1);
        rd_word(SYS + 32'h10); check("R5 device id low loader", s_rd, DID[31:0]);
        rd_word(SYS + 32'h14); check("R5 device id high loader", s_rd, DID[63:32]);
        rd_word(SYS + 32'h20); check("R4 switch reads zero", s_rd, 32'h0);
    endtask

    task automatic t_load_regs();
        wr_word(SYS + 32'h30, 32'h4000_7000);
        wr_word(SYS + 32'h34, 32'h0000_1234);
        for (int i = 0; i < 8; i++) wr_word(SYS + 32'h40 + 32'(4*i), 32'hc0de_0000 + 32'(i));
        rd_word(SYS + 32'h30); check("R6 load addr write", s_rd, 32'h4000_7000);
        rd_word(SYS + 32'h34); check("R6 load size write", s_rd, 32'h0000_1234);
        for (int i = 0; i < 8; i++) begin
            rd_word(SYS + 32'h40 + 32'(4*i));
            check("R6 ident write", s_rd, 32'hc0de_0000 + 32'(i));
        end
    endtask

    task automatic t_secret_once();
        rd_word(SCR + 32'h0); check("R7 word0 first", s_rd, SEC[31:0]);
        rd_word(SCR + 32'h0); check("R7 word0 second", s_rd, 32'h0);
        wr_word(SCR + 32'h4, 32'hffff_ffff);
        rd_word(SCR + 32'h4); check("R7 word1 after write", s_rd, SEC[63:32]);
        rd_word(SCR + 32'h1c); check("R7 word7 first", s_rd, SEC[255:224]);
        rd_word(SCR + 32'h1c); check("R7 word7 second", s_rd, 32'h0);
    endtask

    task automatic t_switch();
        wr_word(SYS + 32'h20, 32'h0);
        #1;
        check("R3 switch write zero", {31'h0, app_mode}, 32'h1);
        rd_word(SYS + 32'h20); check("R4 switch reads ones", s_rd, 32'hffff_ffff);
        wr_word(SYS + 32'h20, 32'h5);
        #1;
        check("R3 stays app", {31'h0, app_mode}, 32'h1);
    endtask

    task automatic t_app_limits();
        rd_word(SCR + 32'h8); check("R5 secret hidden", s_rd, 32'h0);
        rd_word(SYS + 32'h10); check("R5 device id hidden", s_rd, 32'h0);
        access(32'hd000_0000, 1'b0, 2'b00, 32'h0);
        check("R5 scratch no select", {25'h0, s_sel}, 32'h0);
        wr_word(SYS + 32'h30, 32'h1111_1111);
        rd_word(SYS + 32'h30); check("R6 load addr locked", s_rd, 32'h4000_7000);
        wr_word(SYS + 32'h34, 32'h2222_2222);
        rd_word(SYS + 32'h34); check("R6 load size locked", s_rd, 32'h0000_1234);
        wr_word(SYS + 32'h5c, 32'h3333_3333);
        rd_word(SYS + 32'h5c); check("R6 ident locked", s_rd, 32'hc0de_0007);
        rd_word(SYS + 32'h00); check("R8 name A in app", s_rd, NA);
    endtask

    task automatic t_back_to_loader();
        do_reset();
        #1;
        check("R3 reset leaves app", {31'h0, app_mode}, 32'h0);
        rd_word(SCR + 32'h0); check("R7 secret fresh after reset", s_rd, SEC[31:0]);
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_regions();
        t_cores();
        t_narrow();
        t_names();
        t_load_regs();
        t_secret_once();
        t_switch();
        t_app_limits();
        t_back_to_loader();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule